// File: doc/BRIEF.md
# Fractional-Spaced Three-Tap Transmit Equalizer

This block is the digital core of a transmit feed-forward equalizer. It works on an oversampled symbol stream. A serial NRZ bit enters once per unit interval (UI). Each UI is cut into a fixed number of oversamples, paced by a sample strobe. For every oversample the block forms three cursors. The main cursor is the current bit. The post cursor is the main cursor one full UI earlier. The fractional cursor is the main cursor a programmable number of oversamples earlier, which is a fraction of a UI. A current-steering DAC driver takes the signed code that results.

Each bit maps to a level of +1 or -1. Each cursor is scaled by its own unsigned weight. The main term is added and the fractional and post terms are subtracted. Because the fractional tap sits less than one UI behind the main cursor, the de-emphasis peaks above the Nyquist frequency. The low-frequency gain is set by the main weight less the fractional and post weights. New weights and a new delay are first held in shadow registers and take effect only at a UI boundary, so one UI never mixes two settings.

Top module: `frac_ffe_tx`

## Requirements
- R1: After reset, and until one full UI of data has moved into the post tap (the first 10 strobes after reset), `eq_code` is 0.
- R2: The oversample phase counts strobes from 0 to 9 and restarts at 0; the strobe taken at phase 0 (the first strobe after reset, and every tenth after it) is a UI boundary. `tx_bit` is sampled only on that strobe and is held as the main cursor for the whole UI, with bit 1 giving level +1 and bit 0 giving level -1.
- R3: The post cursor equals the main cursor of exactly 10 strobes earlier, and its weighted level is subtracted from the code.
- R4: The fractional cursor equals the main cursor of exactly d strobes earlier, where d is the active delay in oversamples (4 to 8), and its weighted level is subtracted from the code.
- R5: A `dly_sel` value below 4 is used as 4, and a value above 8 is used as 8.
- R6: `dly_sel`, `wt_main`, `wt_frac` and `wt_post` are taken only on the UI-boundary strobe; values presented on other strobes have no effect on any code.
- R7: In a cycle without `samp_en` the phase, the cursors and `eq_code` do not change.
- R8: The code saturates to the signed range of the output width: sums above the largest code give the largest code, and sums below the smallest code give the smallest code.
- R9: Once the post tap holds data, `eq_code` = wt_main·L(main) − wt_frac·L(frac) − wt_post·L(post), where L is the ±1 level. The value is updated after each strobe and uses the weights and delay that were loaded at the most recent UI boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_en | input | 1 | Oversample strobe; one oversample per asserted cycle |
| tx_bit | input | 1 | Serial NRZ data bit, sampled on the UI-boundary strobe |
| dly_sel | input | 4 | Fractional delay in oversamples (clamped to 4..8) |
| wt_main | input | 6 | Unsigned weight of the main cursor |
| wt_frac | input | 6 | Unsigned weight of the fractional cursor (subtracted) |
| wt_post | input | 6 | Unsigned weight of the post cursor (subtracted) |
| eq_code | output | 9 | Signed, saturated DAC code for the current oversample |

## Verification
A wrong phase count moves the point where a bit is sampled. This shows up as a main-cursor level that changes inside a UI, and it appears in `eq_code` within one strobe. A delay line that is off by one stage, or a wrong fractional index, gives a code that is wrong only on the few oversamples after a bit transition. For that reason every strobe is compared against an independent model, and the data patterns have transitions at all delay settings. If a shadow register leaks, a mid-UI change of weight or delay changes the code on the next strobe rather than at the next boundary. Feeding inverted junk values on every non-boundary strobe exposes this at once.

// File: rtl/ffe_fs_pkg.sv
package ffe_fs_pkg;

   // One oversample of a cursor: vld is clear until real data has arrived.
   typedef struct packed {
      logic vld;
      logic one;
   } smp_t;

   localparam smp_t SMP_EMPTY = '{vld: 1'b0, one: 1'b0};

endpackage

// File: rtl/ffe_ui_timer.sv
module ffe_ui_timer #(
   parameter int OSR = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic samp_en,
   output logic ui_edge
);
   localparam int PW = (OSR > 1) ? $clog2(OSR) : 1;

   if (OSR < 2) begin : g_bad_osr
      $error("ffe_ui_timer: OSR must be at least 2");
   end

   logic [PW-1:0] ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph <= '0;
      else if (samp_en)
         ph <= (ph == PW'(OSR - 1)) ? '0 : ph + 1'b1;
   end

   assign ui_edge = samp_en && (ph == '0);

   // R2: the phase never leaves 0..OSR-1
   p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, ph} < (PW + 1)'(OSR)));

   // R7: no strobe, no phase movement
   p_phase_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !samp_en |=> $stable(ph));

endmodule

// File: rtl/ffe_shadow.sv
module ffe_shadow #(
   parameter int WW   = 6,
   parameter int DSW  = 4,
   parameter int DMIN = 4,
   parameter int DMAX = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [DSW-1:0] dly_in,
   input  logic [WW-1:0]  wm_in,
   input  logic [WW-1:0]  wf_in,
   input  logic [WW-1:0]  wp_in,
   output logic [DSW-1:0] d_act,
   output logic [WW-1:0]  wm_act,
   output logic [WW-1:0]  wf_act,
   output logic [WW-1:0]  wp_act
);
   if (DMIN > DMAX) begin : g_bad_range
      $error("ffe_shadow: DMIN exceeds DMAX");
   end
   if (DMAX >= (1 << DSW)) begin : g_bad_width
      $error("ffe_shadow: DSW too narrow for DMAX");
   end

   logic [DSW-1:0] d_clamp;

   always_comb begin
      if (dly_in < DSW'(DMIN))
         d_clamp = DSW'(DMIN);
      else if (dly_in > DSW'(DMAX))
         d_clamp = DSW'(DMAX);
      else
         d_clamp = dly_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_act  <= DSW'(DMIN);
         wm_act <= '0;
         wf_act <= '0;
         wp_act <= '0;
      end else if (load) begin
         d_act  <= d_clamp;
         wm_act <= wm_in;
         wf_act <= wf_in;
         wp_act <= wp_in;
      end
   end

   // R5: the active delay always lies inside the supported window
   p_dly_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (d_act >= DSW'(DMIN)) && (d_act <= DSW'(DMAX)));

   // R6: settings only move on a boundary load
   p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable({d_act, wm_act, wf_act, wp_act}));

endmodule

// File: rtl/ffe_tap_line.sv
module ffe_tap_line
   import ffe_fs_pkg::*;
#(
   parameter int OSR  = 10,
   parameter int DSW  = 4,
   parameter int DMIN = 4,
   parameter int DMAX = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           samp_en,
   input  logic           ui_edge,
   input  logic           tx_bit,
   input  logic [DSW-1:0] d_sel,
   output smp_t           main_s,
   output smp_t           frac_s,
   output smp_t           post_s
);
   if (DMAX >= OSR) begin : g_bad_dmax
      $error("ffe_tap_line: fractional delay must stay below one UI");
   end

   smp_t line [OSR+1];
   smp_t head;

   // New symbol at the boundary, otherwise the held main cursor repeats.
   always_comb begin
      head = line[0];
      if (ui_edge) begin
         head.vld = 1'b1;
         head.one = tx_bit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i <= OSR; i++) line[i] <= SMP_EMPTY;
      end else if (samp_en) begin
         line[0] <= head;
         for (int i = 1; i <= OSR; i++) line[i] <= line[i-1];
      end
   end

   always_comb begin
      frac_s = line[DMIN];
      for (int k = DMIN; k <= DMAX; k++)
         if (d_sel == DSW'(k)) frac_s = line[k];
   end

   assign main_s = line[0];
   assign post_s = line[OSR];

   // R2: the main cursor holds still on strobes inside a UI
   p_main_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_en && !ui_edge) |=> (main_s == $past(main_s)));

endmodule

// File: rtl/frac_ffe_tx.sv
module frac_ffe_tx
   import ffe_fs_pkg::*;
#(
   parameter int OSR  = 10,
   parameter int WW   = 6,
   parameter int OW   = 9,
   parameter int DSW  = 4,
   parameter int DMIN = 4,
   parameter int DMAX = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 samp_en,
   input  logic                 tx_bit,
   input  logic [DSW-1:0]       dly_sel,
   input  logic [WW-1:0]        wt_main,
   input  logic [WW-1:0]        wt_frac,
   input  logic [WW-1:0]        wt_post,
   output logic signed [OW-1:0] eq_code
);
   localparam int SW = WW + 3;

   if (OW < 2) begin : g_bad_ow
      $error("frac_ffe_tx: OW must be at least 2");
   end

   logic           ui_edge;
   logic [DSW-1:0] d_act;
   logic [WW-1:0]  wm_act, wf_act, wp_act;
   smp_t           main_s, frac_s, post_s;

   ffe_ui_timer #(.OSR(OSR)) u_timer (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .ui_edge(ui_edge)
   );

   ffe_shadow #(.WW(WW), .DSW(DSW), .DMIN(DMIN), .DMAX(DMAX)) u_shadow (
      .clk(clk), .rst_n(rst_n), .load(ui_edge),
      .dly_in(dly_sel), .wm_in(wt_main), .wf_in(wt_frac), .wp_in(wt_post),
      .d_act(d_act), .wm_act(wm_act), .wf_act(wf_act), .wp_act(wp_act)
   );

   ffe_tap_line #(.OSR(OSR), .DSW(DSW), .DMIN(DMIN), .DMAX(DMAX)) u_line (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .ui_edge(ui_edge),
      .tx_bit(tx_bit), .d_sel(d_act),
      .main_s(main_s), .frac_s(frac_s), .post_s(post_s)
   );

   function automatic logic signed [SW-1:0] tap_term(smp_t s, logic [WW-1:0] w);
      logic signed [SW-1:0] mag;
      mag = $signed({3'b000, w});
      if (!s.vld) return '0;
      return s.one ? mag : -mag;
   endfunction

   logic signed [SW-1:0] raw;
   logic signed [OW-1:0] code_sat;

   assign raw = tap_term(main_s, wm_act) - tap_term(frac_s, wf_act)
              - tap_term(post_s, wp_act);

   if (OW >= SW) begin : g_wide
      assign code_sat = OW'(raw);
   end else begin : g_clip
      localparam logic signed [SW-1:0] HI = SW'((1 << (OW - 1)) - 1);
      localparam logic signed [SW-1:0] LO = SW'(-(1 << (OW - 1)));
      always_comb begin
         if (raw > HI)
            code_sat = HI[OW-1:0];
         else if (raw < LO)
            code_sat = LO[OW-1:0];
         else
            code_sat = raw[OW-1:0];
      end
   end

   assign eq_code = post_s.vld ? code_sat : '0;

   // R7: without a strobe the driver code stays put
   p_code_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !samp_en |=> $stable(eq_code));

   // R1: code stays zero while the fractional tap is still empty
   p_fill_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !frac_s.vld |-> (eq_code == '0));

endmodule

// File: tb/frac_ffe_tx_bench.sv
`timescale 1ns/1ps
module frac_ffe_tx_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic samp_en = 1'b0;
   logic tx_bit = 1'b0;
   logic [3:0] dly_sel = 4'd4;
   logic [5:0] wt_main = '0, wt_frac = '0, wt_post = '0;
   logic signed [8:0] eq_code;
   logic signed [6:0] eq_small;

   always #10 clk = ~clk;

   frac_ffe_tx u_frac_ffe_tx (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .tx_bit(tx_bit),
      .dly_sel(dly_sel), .wt_main(wt_main), .wt_frac(wt_frac),
      .wt_post(wt_post), .eq_code(eq_code)
   );

   // Narrow-output copy that exercises saturation (range -64..63)
   frac_ffe_tx #(.OW(7)) u_frac_ffe_tx_sat (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .tx_bit(tx_bit),
      .dly_sel(dly_sel), .wt_main(wt_main), .wt_frac(wt_frac),
      .wt_post(wt_post), .eq_code(eq_small)
   );

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   // Bench model state, indexed by UI number since reset
   int n = 0;
   bit bh [64];
   int dh [64], wmh [64], wfh [64], wph [64];
   int last_exp = 0;

   // Row: {tag, bit, dly, w_main, w_frac, w_post}
   localparam int ROWS = 16;
   localparam logic [26:0] TBL [ROWS] = '{
      {4'd1, 1'b1, 4'd4, 6'd30, 6'd10, 6'd5 },  // R1 fill period
      {4'd2, 1'b0, 4'd4, 6'd30, 6'd0,  6'd0 },  // R2 main only
      {4'd2, 1'b1, 4'd4, 6'd30, 6'd0,  6'd0 },  // R2
      {4'd3, 1'b1, 4'd5, 6'd0,  6'd0,  6'd20},  // R3 post only
      {4'd3, 1'b0, 4'd5, 6'd0,  6'd0,  6'd20},  // R3
      {4'd4, 1'b1, 4'd4, 6'd10, 6'd25, 6'd0 },  // R4 delay 4
      {4'd4, 1'b0, 4'd6, 6'd10, 6'd25, 6'd0 },  // R4 delay 6
      {4'd4, 1'b1, 4'd8, 6'd10, 6'd25, 6'd0 },  // R4 delay 8
      {4'd5, 1'b0, 4'd0, 6'd10, 6'd25, 6'd0 },  // R5 low clamp
      {4'd5, 1'b1, 4'd15,6'd10, 6'd25, 6'd0 },  // R5 high clamp
      {4'd5, 1'b0, 4'd9, 6'd12, 6'd20, 6'd7 },  // R5
      {4'd6, 1'b1, 4'd7, 6'd40, 6'd11, 6'd3 },  // R6 junk mid-UI
      {4'd8, 1'b1, 4'd5, 6'd63, 6'd63, 6'd63},  // R8 full scale
      {4'd8, 1'b0, 4'd5, 6'd63, 6'd63, 6'd63},  // R8
      {4'd8, 1'b1, 4'd6, 6'd63, 6'd63, 6'd63},  // R8
      {4'd9, 1'b0, 4'd4, 6'd17, 6'd9,  6'd31}   // R9 mixed weights
   };

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int lvl(int ui);
      return bh[ui] ? 1 : -1;
   endfunction

   function automatic int exp_raw(int k);
      int u;
      if (k <= 10) return 0;
      u = (k - 1) / 10;
      return wmh[u] * lvl(u) - wfh[u] * lvl((k - dh[u] - 1) / 10)
           - wph[u] * lvl((k - 11) / 10);
   endfunction

   function automatic int clip7(int v);
      if (v > 63) return 63;
      if (v < -64) return -64;
      return v;
   endfunction

   // One strobe: called at a falling edge, checks after the next one
   task automatic strobe(input logic b, input logic [3:0] d,
                         input logic [5:0] a, input logic [5:0] f,
                         input logic [5:0] p, input int tag);
      int u, e, dc;
      samp_en = 1'b1;
      if ((n % 10) == 0) begin
         u = n / 10;
         dc = (d < 4) ? 4 : ((d > 8) ? 8 : int'(d));
         bh[u] = b; dh[u] = dc; wmh[u] = a; wfh[u] = f; wph[u] = p;
         tx_bit = b; dly_sel = d; wt_main = a; wt_frac = f; wt_post = p;
      end else begin
         // junk that must be ignored off the boundary
         tx_bit = ~b; dly_sel = ~d; wt_main = ~a; wt_frac = ~f; wt_post = ~p;
      end
      @(negedge clk);
      n++;
      e = exp_raw(n);
      last_exp = e;
      chk($sformatf("R%0d code n=%0d", tag, n), int'($signed(eq_code)), e);
      chk($sformatf("R8 sat code n=%0d", n), int'($signed(eq_small)), clip7(e));
      samp_en = 1'b0;
      if ((n % 3) == 0) begin
         tx_bit = ~tx_bit; dly_sel = dly_sel + 4'd3;
         wt_main = ~wt_main; wt_frac = wt_frac + 6'd9; wt_post = ~wt_post;
         @(negedge clk);
         chk("R7 idle hold", int'($signed(eq_code)), last_exp);
         chk("R7 idle hold sat", int'($signed(eq_small)), clip7(last_exp));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset state", int'($signed(eq_code)), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", int'($signed(eq_code)), 0);

      for (int r = 0; r < ROWS; r++) begin
         for (int ph = 0; ph < 10; ph++) begin
            strobe(TBL[r][22], TBL[r][21:18], TBL[r][17:12],
                   TBL[r][11:6], TBL[r][5:0], int'(TBL[r][26:23]));
         end
      end

      // Reset mid-run clears everything (R1)
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid-run reset", int'($signed(eq_code)), 0);
      rst_n = 1'b1;
      n = 0;
      for (int ph = 0; ph < 10; ph++) strobe(1'b1, 4'd5, 6'd20, 6'd5, 6'd3, 1);
      chk("R1 zero through first UI", int'($signed(eq_code)), 0);
      // R9 hand value: all levels +1 -> 20 - 5 - 3 = 12
      strobe(1'b1, 4'd5, 6'd20, 6'd5, 6'd3, 9);
      chk("R9 hand value", int'($signed(eq_code)), 12);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule